// File: doc/BRIEF.md
# Rotating Priority Resolver with In-Service Tracking

This block picks one winner among a set of interrupt request lines (eight by default). Priority is circular. The search starts at a programmable base line and moves upward through the line numbers, wrapping at the top. The block keeps an in-service register. It raises its interrupt output only when the best pending request outranks every line already being serviced. The ranking is strict: a pending line of equal rank does not raise the output.

The surrounding controller presents the masked pending vector. It pulses `ack` when the processor accepts the interrupt. When the resolver raises the output, it also reports the winning line number. On an accepted acknowledge the winner's in-service bit is set. In automatic end-of-interrupt mode the bit is never set, and the base can optionally rotate to the line after the winner. The controller's command decoder can clear a single in-service bit and can load the base line directly.

In a primary unit (the one with a secondary unit chained to its cascade line), a nested mode can be turned on. In this mode the cascade line's in-service bit is left out of the current-priority comparison. The secondary can then interrupt again through that same line.

Top module: `rot_prio_core`

## Requirements
- R1: Rank is counted from the base line `rot_ofs` upward, modulo N. The lowest-ranked set bit of `req_vec` wins. `sel_line` reports the winner's absolute line number (rank + `rot_ofs`) mod N while `irq_out` is high.
- R2: With `req_vec` all zero, `irq_out` is low and `sel_line` is 0.
- R3: `irq_out` is high only when the winner's rank is strictly below the rank of the best set in-service bit, counted from the same base. An equal rank keeps it low, and `sel_line` then reads 0.
- R4: With parameter IS_PRIMARY=1 and `nest_en` high, in-service bit CASCADE_LINE (2 by default) takes no part in the comparison. A request on line 2 can then win while in-service bit 2 is set.
- R5: `ack` while `irq_out` is high with `auto_eoi` low sets in-service bit `sel_line` at the next clock edge.
- R6: `ack` while `irq_out` is high with `auto_eoi` high leaves `isr_vec` unchanged.
- R7: `ack` while `irq_out` is high with both `auto_eoi` and `auto_rot` high makes `rot_ofs` equal (`sel_line` + 1) mod N at the next edge. With `auto_rot` low, `rot_ofs` is unchanged.
- R8: `ack` while `irq_out` is low changes neither `isr_vec` nor `rot_ofs`.
- R9: `clr_req` clears in-service bit `clr_idx`, and `ofs_load` loads `rot_ofs` from `ofs_val`. If a set and a clear hit the same bit in one cycle, the set wins. If a rotation and a load arrive together, the rotation wins.
- R10: While `rst_n` is low, `isr_vec` clears to zero and `rot_ofs` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vec | input | N | Masked pending request vector |
| ack | input | 1 | Acknowledge strobe from the processor side |
| auto_eoi | input | 1 | Automatic end-of-interrupt enable |
| auto_rot | input | 1 | Rotate base on automatic end-of-interrupt |
| nest_en | input | 1 | Nested mode: ignore cascade in-service bit (primary only) |
| clr_req | input | 1 | Clear one in-service bit |
| clr_idx | input | $clog2(N) | Line whose in-service bit is cleared |
| ofs_load | input | 1 | Load the rotation base |
| ofs_val | input | $clog2(N) | Value for the rotation base |
| irq_out | output | 1 | Interrupt request to the processor side |
| sel_line | output | $clog2(N) | Winning line number, 0 when `irq_out` is low |
| isr_vec | output | N | In-service register |
| rot_ofs | output | $clog2(N) | Current rotation base |

## Verification
The bound checker enforces several relations on every cycle:
- the winner is really pending and, outside nested mode, not already in service;
- an idle request vector keeps the output low;
- an accepted acknowledge sets the right in-service bit, or leaves the register alone under automatic end-of-interrupt, and rotates the base when asked;
- an unaccepted acknowledge changes nothing;
- reset clears both registers.

Only the bench's scenarios show the rest:
- the exact wrap-around order of the search from a nonzero base;
- the equal-rank blocking case;
- the nested-mode exception on line 2 turning on and off;
- the precedence rules when a set meets a clear, or a rotation meets a load, in the same cycle.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  // acknowledge-time behaviour bundle used inside the core
  typedef struct packed {
    logic auto_eoi;
    logic auto_rot;
    logic nest;
  } rpr_mode_t;
endpackage

// File: rtl/rpr_search.sv
module rpr_search #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] base,
  output logic [W:0]   rel
);
  // rank of the first set bit walking up from base; N means empty
  function automatic logic [W:0] find_rel(input logic [N-1:0] v,
                                          input logic [W-1:0] b);
    logic [W:0]   r;
    logic [W-1:0] idx;
    r = (W+1)'(N);
    for (int i = N-1; i >= 0; i--) begin
      idx = b + i[W-1:0];
      if (v[idx]) r = i[W:0];
    end
    return r;
  endfunction

  assign rel = find_rel(vec, base);
endmodule

// File: rtl/rpr_isr_bank.sv
module rpr_isr_bank #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_idx,
  input  logic         clr_en,
  input  logic [W-1:0] clr_idx,
  output logic [N-1:0] isr
);
  logic [N-1:0] isr_q;
  logic [N-1:0] set_mask, clr_mask;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (set_en) set_mask[set_idx] = 1'b1;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~clr_mask) | set_mask;
  end

  assign isr = isr_q;
endmodule

// File: rtl/rpr_base_reg.sv
module rpr_base_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rot_en,
  input  logic [W-1:0] rot_line,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] base
);
  logic [W-1:0] base_q;

  // the line after the acknowledged one becomes the new first rank
  function automatic logic [W-1:0] after_line(input logic [W-1:0] l);
    return l + {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (rot_en)  base_q <= after_line(rot_line);
    else if (load_en) base_q <= load_val;
  end

  assign base = base_q;
endmodule

// File: rtl/rot_prio_core.sv
module rot_prio_core #(
  parameter int N            = 8,
  parameter bit IS_PRIMARY   = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_vec,
  input  logic         ack,
  input  logic         auto_eoi,
  input  logic         auto_rot,
  input  logic         nest_en,
  input  logic         clr_req,
  input  logic [W-1:0] clr_idx,
  input  logic         ofs_load,
  input  logic [W-1:0] ofs_val,
  output logic         irq_out,
  output logic [W-1:0] sel_line,
  output logic [N-1:0] isr_vec,
  output logic [W-1:0] rot_ofs
);
  import rpr_pkg::*;

  rpr_mode_t    mode;
  logic [N-1:0] isr_q, isr_view, nest_hide;
  logic [W-1:0] base_q, win_line;
  logic [W:0]   pend_rel, serv_rel;
  logic         ack_take, isr_set_en, base_rot_en;

  assign mode = '{auto_eoi: auto_eoi, auto_rot: auto_rot, nest: nest_en};

  // cascade in-service bit hidden only on a primary unit in nested mode
  generate
    if (IS_PRIMARY) begin : g_nest
      always_comb begin
        nest_hide = '0;
        nest_hide[CASCADE_LINE] = mode.nest;
      end
    end else begin : g_flat
      assign nest_hide = '0;
    end
  endgenerate

  assign isr_view = isr_q & ~nest_hide;

  rpr_search #(.N(N)) u_pend (.vec(req_vec),  .base(base_q), .rel(pend_rel));
  rpr_search #(.N(N)) u_serv (.vec(isr_view), .base(base_q), .rel(serv_rel));

  assign irq_out  = pend_rel < serv_rel;
  assign win_line = pend_rel[W-1:0] + base_q;
  assign sel_line = irq_out ? win_line : '0;

  assign ack_take    = ack && irq_out;
  assign isr_set_en  = ack_take && !mode.auto_eoi;
  assign base_rot_en = ack_take && mode.auto_eoi && mode.auto_rot;

  rpr_isr_bank #(.N(N)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .set_en(isr_set_en), .set_idx(win_line),
    .clr_en(clr_req), .clr_idx(clr_idx),
    .isr(isr_q)
  );

  rpr_base_reg #(.W(W)) u_base (
    .clk(clk), .rst_n(rst_n),
    .rot_en(base_rot_en), .rot_line(win_line),
    .load_en(ofs_load), .load_val(ofs_val),
    .base(base_q)
  );

  assign isr_vec = isr_q;
  assign rot_ofs = base_q;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker #(
  parameter int N            = 8,
  parameter bit IS_PRIMARY   = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int W = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_vec,
  input logic         ack,
  input logic         auto_eoi,
  input logic         auto_rot,
  input logic         nest_en,
  input logic         clr_req,
  input logic         ofs_load,
  input logic         irq_out,
  input logic [W-1:0] sel_line,
  input logic [N-1:0] isr_vec,
  input logic [W-1:0] rot_ofs
);
  logic cascade_exempt;
  assign cascade_exempt = IS_PRIMARY && nest_en && (sel_line == W'(CASCADE_LINE));

  assert_win_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> req_vec[sel_line]);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vec == '0) |-> (!irq_out && sel_line == '0));

  // strictly higher rank: the winner is not itself in service (R3, R4 exception)
  assert_strict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !cascade_exempt) |-> !isr_vec[sel_line]);

  assert_ack_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !auto_eoi) |=> isr_vec[$past(sel_line)]);

  assert_aeoi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && auto_eoi && !clr_req) |=> (isr_vec == $past(isr_vec)));

  assert_rotate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && auto_eoi && auto_rot) |=>
      (rot_ofs == ($past(sel_line) + {{(W-1){1'b0}}, 1'b1})));

  assert_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out && !clr_req && !ofs_load) |=> ($stable(isr_vec) && $stable(rot_ofs)));

  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |=> (isr_vec == '0 && rot_ofs == '0));
endmodule

bind rot_prio_core rpr_checker #(.N(N), .IS_PRIMARY(IS_PRIMARY), .CASCADE_LINE(CASCADE_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .ack(ack), .auto_eoi(auto_eoi),
  .auto_rot(auto_rot), .nest_en(nest_en), .clr_req(clr_req), .ofs_load(ofs_load),
  .irq_out(irq_out), .sel_line(sel_line), .isr_vec(isr_vec), .rot_ofs(rot_ofs)
);

// File: tb/sim_rot_prio_core.sv
module sim_rot_prio_core;
  localparam int CLK_T = 10;

  typedef struct {
    logic       irq;
    logic [2:0] line;
    logic [7:0] isr;
    logic [2:0] ofs;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_vec = '0;
  logic       ack = 0, auto_eoi = 0, auto_rot = 0, nest_en = 0;
  logic       clr_req = 0, ofs_load = 0;
  logic [2:0] clr_idx = '0, ofs_val = '0;
  logic       irq_out;
  logic [2:0] sel_line, rot_ofs;
  logic [7:0] isr_vec;

  exp_t exp_q[$];
  int   n_chk = 0, n_err = 0;
  logic [7:0] m_isr = '0;
  logic [2:0] m_ofs = '0;
  bit   done = 0;

  always #(CLK_T/2) clk = ~clk;

  rot_prio_core u0 (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .ack(ack), .auto_eoi(auto_eoi),
    .auto_rot(auto_rot), .nest_en(nest_en), .clr_req(clr_req), .clr_idx(clr_idx),
    .ofs_load(ofs_load), .ofs_val(ofs_val), .irq_out(irq_out), .sel_line(sel_line),
    .isr_vec(isr_vec), .rot_ofs(rot_ofs)
  );

  // bench ranking: rotate the doubled vector down by the base, take lowest bit
  function automatic int b_rank(input logic [7:0] v, input logic [2:0] b);
    logic [15:0] dbl;
    logic [7:0]  rv;
    dbl = {v, v} >> b;
    rv  = dbl[7:0];
    for (int k = 0; k < 8; k++) if (rv[k]) return k;
    return 8;
  endfunction

  task automatic step(input logic [7:0] rq, input bit ak, input bit ae, input bit ar,
                      input bit ns, input bit cl, input logic [2:0] ci,
                      input bit ld, input logic [2:0] lv, input string tag);
    exp_t e;
    int   pr, sr;
    logic [7:0] view;
    @(negedge clk);
    req_vec = rq; ack = ak; auto_eoi = ae; auto_rot = ar; nest_en = ns;
    clr_req = cl; clr_idx = ci; ofs_load = ld; ofs_val = lv;
    #(CLK_T/4);
    view   = m_isr & ~(ns ? 8'h04 : 8'h00);
    pr     = b_rank(rq, m_ofs);
    sr     = b_rank(view, m_ofs);
    e.irq  = pr < sr;
    e.line = e.irq ? 3'(pr + int'(m_ofs)) : 3'd0;
    e.isr  = m_isr;
    e.ofs  = m_ofs;
    e.tag  = tag;
    exp_q.push_back(e);
    // state after the coming edge
    if (cl) m_isr[ci] = 1'b0;
    if (ak && e.irq && !ae) m_isr[e.line] = 1'b1;
    if (ak && e.irq && ae && ar) m_ofs = e.line + 3'd1;
    else if (ld) m_ofs = lv;
  endtask

  // monitor: pops each expected item and compares with the outputs
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      n_chk++;
      if (irq_out !== e.irq || sel_line !== e.line || isr_vec !== e.isr || rot_ofs !== e.ofs) begin
        n_err++;
        $display("FAIL %s: got irq=%0b line=%0d isr=%02h ofs=%0d, expected irq=%0b line=%0d isr=%02h ofs=%0d",
                 e.tag, irq_out, sel_line, isr_vec, rot_ofs, e.irq, e.line, e.isr, e.ofs);
      end
    end
  end

  initial begin
    #(CLK_T * 5000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(8'h00, 0,0,0,0, 0,3'd0, 0,3'd0, "R10 R2 reset state, idle");
    step(8'h28, 1,0,0,0, 0,3'd0, 0,3'd0, "R1 R5 base 0 picks line 3, ack sets isr");
    step(8'h28, 1,0,0,0, 0,3'd0, 0,3'd0, "R3 R8 equal rank blocked, ack ignored");
    step(8'h02, 0,0,0,0, 0,3'd0, 0,3'd0, "R3 higher line 1 preempts");
    step(8'h20, 0,0,0,0, 1,3'd3, 0,3'd0, "R3 line 5 below in-service 3, clear 3");
    step(8'h20, 0,0,0,0, 0,3'd0, 1,3'd6, "R9 cleared isr, load base 6");
    step(8'h21, 1,1,1,0, 0,3'd0, 0,3'd0, "R1 R6 R7 wrap to line 0, rotate");
    step(8'h21, 1,1,0,0, 0,3'd0, 0,3'd0, "R7 R6 base 1 picks line 5, no rotate");
    step(8'h21, 0,0,0,0, 0,3'd0, 1,3'd0, "R7 base held, load 0");
    step(8'h04, 1,0,0,0, 0,3'd0, 0,3'd0, "R5 line 2 into service");
    step(8'h04, 0,0,0,0, 0,3'd0, 0,3'd0, "R4 nested off blocks line 2");
    step(8'h04, 0,0,0,1, 0,3'd0, 0,3'd0, "R4 nested on passes line 2");
    step(8'h10, 0,0,0,1, 0,3'd0, 0,3'd0, "R4 nested on passes line 4");
    step(8'h10, 0,0,0,0, 1,3'd2, 0,3'd0, "R4 nested off blocks line 4, clear 2");
    step(8'h80, 1,1,1,0, 0,3'd0, 1,3'd3, "R9 rotate beats load");
    step(8'h40, 1,0,0,0, 1,3'd6, 0,3'd0, "R9 set beats clear on line 6");
    step(8'h00, 0,0,0,0, 0,3'd0, 0,3'd0, "R9 R2 final state");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; m_isr = '0; m_ofs = '0;
    step(8'h00, 0,0,0,0, 0,3'd0, 0,3'd0, "R10 second reset clears state");
    wait (exp_q.size() == 0);
    #(CLK_T);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule